// File: doc/BRIEF.md
# Prescaled Modulus Timer Counter

This block is an up-counting timer clocked by the module clock through a programmable binary prescaler. Software sets a divide ratio of 2^n (n from 0 to 7) and the counter advances by one on each prescaled tick. In free-run mode it walks through its whole range and wraps to zero, raising a sticky overflow flag. With clear-on-match enabled, a tick on which the counter equals the channel-7 compare value returns the counter to zero instead. This turns the timer into a modulus counter whose period is the compare value plus one ticks.

A small register bus gives access to a control word, the compare value, the live count and the overflow status. Every tick on which the counter equals the compare value produces a one-clock match pulse. An interrupt request is raised while the overflow flag is set and overflow interrupts are enabled. The asynchronous active-low reset is released to the logic through a two-stage synchronizer, so the logic starts two clocks after the reset input goes high.

Top module: `tmr_modcnt`

## Requirements
- R1: With prescale select n, a tick occurs once every 2^n module clocks, and the count changes only on a tick, normally by +1.
- R2: With clear-on-match disabled (control bit 1 = 0), the count runs through every value and goes from all-ones to 0 on a tick.
- R3: With clear-on-match enabled (control bit 1 = 1), a tick on which the count equals the compare value sets the count to 0.
- R4: With clear-on-match enabled and compare value 0, the count stays at 0.
- R5: With clear-on-match enabled and compare value all-ones, the count goes from all-ones to 0 and the overflow flag is not set.
- R6: In any other case, the tick that takes the count from all-ones to 0 sets the overflow flag (status register bit 0, `ovf_flag`) from the next clock. Writing 1 to status bit 0 clears the flag, but a set in the same clock wins.
- R7: `irq` is high exactly when the overflow flag is 1 and control bit 0 (interrupt enable) is 1.
- R8: `cmp_match` is high for one clock after each tick on which the count equals the compare value, whether or not clear-on-match is enabled.
- R9: Addresses: 0 is control (bit 0 interrupt enable, bit 1 clear-on-match, bits 4:2 prescale select, other bits read 0), 1 is compare (read/write), 2 is count (read-only), 3 is status (bit 0 overflow, other bits read 0). After reset all of these read 0 and the outputs are low. A write may be made at any time and takes effect at the next clock. Reads are combinational.
- R10: A control write that changes the prescale select restarts the divider: no tick occurs in that clock, and the next tick comes a full 2^n clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| cmp_match | output | 1 | One-clock pulse on a compare-7 hit |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with an 8-bit counter, the default 3-bit prescale select and a 16-bit data bus. With the narrower counter, free-run wraps, all-ones compare values and modulus periods are reached within a few hundred ticks, while every divide ratio up to 128 still gets exercised. Long random runs at small divide ratios then produce many overflows, clears, compare hits and mid-period select changes. These are checked against a model inside the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMP  = 2'd1,
    REG_CNT  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int CTL_IRQ_BIT  = 0;
  localparam int CTL_CRST_BIT = 1;
  localparam int CTL_PS_LSB   = 2;
  localparam int STAT_OVF_BIT = 0;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] sel,
  input  logic            sel_chg,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, limit;
  logic             raw_tick;

  // terminal value 2^sel - 1: bit i set when i < sel
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      limit[i] = (i < int'(sel));
    end
  end

  always_comb begin
    raw_tick = (div_q == limit);
    tick     = raw_tick & ~sel_chg;
    if (sel_chg || raw_tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             crst_en,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             match_q, match_d;
  logic             hit, clr, at_max;

  always_comb begin
    hit      = tick && (cnt_q == cmp);
    clr      = hit && crst_en;
    at_max   = (cnt_q == CNT_MAX);
    wrap_evt = tick && at_max && !clr;
    match_d  = hit;
    cnt_d    = cnt_q;
    if (tick) begin
      if (clr || at_max) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_d;
      if (tick) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign cnt   = cnt_q;
  assign match = match_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap_evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_en,
  output logic              crst_en,
  output logic [PS_W-1:0]   ps_sel,
  output logic              sel_chg,
  output logic [CNT_W-1:0]  cmp,
  output logic              ovf
);
  logic              irq_en_q, irq_en_d;
  logic              crst_q, crst_d;
  logic [PS_W-1:0]   ps_q, ps_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic              ovf_q, ovf_d;
  logic              wr_ctrl, wr_cmp, wr_stat;

  always_comb begin
    wr_ctrl  = wr && (addr == REG_CTRL);
    wr_cmp   = wr && (addr == REG_CMP);
    wr_stat  = wr && (addr == REG_STAT);
    irq_en_d = irq_en_q;
    crst_d   = crst_q;
    ps_d     = ps_q;
    cmp_d    = cmp_q;
    if (wr_ctrl) begin
      irq_en_d = wdata[CTL_IRQ_BIT];
      crst_d   = wdata[CTL_CRST_BIT];
      ps_d     = wdata[CTL_PS_LSB +: PS_W];
    end
    if (wr_cmp) begin
      cmp_d = wdata[CNT_W-1:0];
    end
    sel_chg = wr_ctrl && (ps_d != ps_q);
    ovf_d   = wrap_evt | (ovf_q & ~(wr_stat & wdata[STAT_OVF_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      crst_q   <= 1'b0;
      ps_q     <= '0;
      cmp_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      if (wr_ctrl) begin
        irq_en_q <= irq_en_d;
        crst_q   <= crst_d;
        ps_q     <= ps_d;
      end
      if (wr_cmp) begin
        cmp_q <= cmp_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_CTRL: begin
        rdata[CTL_IRQ_BIT]             = irq_en_q;
        rdata[CTL_CRST_BIT]            = crst_q;
        rdata[CTL_PS_LSB +: PS_W]      = ps_q;
      end
      REG_CMP:  rdata[CNT_W-1:0]       = cmp_q;
      REG_CNT:  rdata[CNT_W-1:0]       = cnt;
      default:  rdata[STAT_OVF_BIT]    = ovf_q;
    endcase
  end

  assign irq_en  = irq_en_q;
  assign crst_en = crst_q;
  assign ps_sel  = ps_q;
  assign cmp     = cmp_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/tmr_modcnt.sv
module tmr_modcnt #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cmp_match,
  output logic              ovf_flag,
  output logic              irq
);
  logic             srst_n;
  logic             tick, sel_chg, wrap_evt;
  logic             irq_en, crst_en;
  logic [PS_W-1:0]  ps_sel;
  logic [CNT_W-1:0] cmp, cnt;

  tmr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk     (clk),
    .rst_n   (srst_n),
    .sel     (ps_sel),
    .sel_chg (sel_chg),
    .tick    (tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (srst_n),
    .tick     (tick),
    .crst_en  (crst_en),
    .cmp      (cmp),
    .cnt      (cnt),
    .match    (cmp_match),
    .wrap_evt (wrap_evt)
  );

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .PS_W(PS_W)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .wrap_evt (wrap_evt),
    .rdata    (bus_rdata),
    .irq_en   (irq_en),
    .crst_en  (crst_en),
    .ps_sel   (ps_sel),
    .sel_chg  (sel_chg),
    .cmp      (cmp),
    .ovf      (ovf_flag)
  );

  assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/tmr_modcnt_chk.sv
module tmr_modcnt_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             crst_en,
  input logic             ovf,
  input logic             irq_en,
  input logic             irq,
  input logic             match,
  input logic             sel_chg,
  input logic [PS_W-1:0]  ps_sel
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt == $past(cnt));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(crst_en && cnt == cmp) && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !crst_en && cnt == CNT_MAX) |=> cnt == '0);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && crst_en && cnt == cmp) |=> cnt == '0);

  assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (crst_en && cmp == '0 && cnt == '0 && !sel_chg) |=> cnt == '0);

  assert_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && crst_en && cnt == cmp && !ovf) |=> !ovf);

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == CNT_MAX && !(crst_en && cnt == cmp)) |=> ovf);

  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf && irq_en));

  assert_irq_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && irq_en) |-> irq);

  assert_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(tick && cnt == cmp));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> (ps_sel == '0) || !tick);
endmodule

bind tmr_modcnt tmr_modcnt_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .tick    (tick),
  .cnt     (cnt),
  .cmp     (cmp),
  .crst_en (crst_en),
  .ovf     (ovf_flag),
  .irq_en  (irq_en),
  .irq     (irq),
  .match   (cmp_match),
  .sel_chg (sel_chg),
  .ps_sel  (ps_sel)
);

// File: tb/tmr_modcnt_test.sv
module tmr_modcnt_test;
  localparam int CW   = 8;
  localparam int DW   = 16;
  localparam int PW   = 3;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          cmp_match, ovf_flag, irq;

  tmr_modcnt #(.CNT_W(CW), .DATA_W(DW), .PS_W(PW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_match (cmp_match),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
  );

  always #4 clk = ~clk;

  int nchecks = 0;
  int nfail   = 0;

  // reference state
  int m_div = 0, m_cnt = 0, m_cmp = 0, m_sel = 0, since_sel = 1000;
  bit m_ovf = 0, m_match = 0, m_irqen = 0, m_crst = 0;

  task automatic check(input string tag, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      if (nfail <= 40) $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_read(input int a);
    case (a)
      0: return (m_sel << 2) | (int'(m_crst) << 1) | int'(m_irqen);
      1: return m_cmp;
      2: return m_cnt;
      default: return int'(m_ovf);
    endcase
  endfunction

  function automatic string cnt_tag();
    if (since_sel <= (1 << m_sel) + 1) return "R10";
    if (m_crst && m_cmp == 0) return "R4";
    if (m_crst) return "R3";
    if (m_sel != 0) return "R1";
    return "R2";
  endfunction

  task automatic step(input bit wr, input int a, input int d);
    int lim;
    bit tk, selchg, hit, wrap;
    @(negedge clk);
    // compare outputs with the present reference state
    if (bus_addr == 2'd2) check(cnt_tag(), int'(bus_rdata), exp_read(2));
    else if (bus_addr == 2'd3) check("R6", int'(bus_rdata), exp_read(3));
    else check("R9", int'(bus_rdata), exp_read(int'(bus_addr)));
    check((m_crst && m_cmp == MAXV) ? "R5" : "R6", int'(ovf_flag), int'(m_ovf));
    check("R7", int'(irq), int'(m_ovf && m_irqen));
    check("R8", int'(cmp_match), int'(m_match));
    // advance reference to the next rising edge
    lim    = (1 << m_sel) - 1;
    selchg = wr && a == 0 && (((d >> 2) & 7) != m_sel);
    tk     = (m_div == lim) && !selchg;
    hit    = tk && (m_cnt == m_cmp);
    wrap   = tk && (m_cnt == MAXV) && !(m_crst && hit);
    m_match = hit;
    m_ovf   = wrap | (m_ovf & !(wr && a == 3 && d[0]));
    if (tk) m_cnt = (m_crst && hit) ? 0 : ((m_cnt == MAXV) ? 0 : m_cnt + 1);
    m_div     = (selchg || tk) ? 0 : m_div + 1;
    since_sel = selchg ? 0 : since_sel + 1;
    if (wr && a == 0) begin
      m_irqen = d[0];
      m_crst  = d[1];
      m_sel   = (d >> 2) & 7;
    end
    if (wr && a == 1) m_cmp = d & MAXV;
    bus_wr    = wr;
    bus_addr  = a[1:0];
    bus_wdata = d[DW-1:0];
  endtask

  task automatic idle(input int n, input int a);
    for (int i = 0; i < n; i++) step(1'b0, a, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
  endtask

  initial begin
    #(8 * 190000);
    nchecks++;
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", int'(bus_rdata), 0);
    check("R9", int'(cmp_match), 0);
    check("R9", int'(ovf_flag), 0);
    check("R9", int'(irq), 0);
    // R2/R6/R7: free run with interrupt enabled, divide by 1
    step(1'b1, 0, 16'hffe1);  // irq_en=1, upper bits ignored -> sel from bits 4:2 = 0
    idle(1, 0);               // R9 readback: unused bits read 0
    idle(300, 2);
    idle(2, 3);
    step(1'b1, 3, 1);         // R6 clear
    idle(3, 3);
    // R3: modulus mode, divide by 2, compare 0x40
    step(1'b1, 1, 16'h0040);
    step(1'b1, 0, (1 << 2) | 2 | 1);
    idle(400, 2);
    // R4: compare 0 holds count at 0
    step(1'b1, 1, 0);
    step(1'b1, 0, 2);
    idle(60, 2);
    // R5: compare all-ones, no overflow
    step(1'b1, 1, MAXV);
    step(1'b1, 3, 1);
    idle(700, 2);
    idle(3, 3);
    // R10: select changes in mid period
    step(1'b1, 0, 3 << 2);
    idle(5, 2);
    step(1'b1, 0, 5 << 2);
    idle(70, 2);
    step(1'b1, 0, 7 << 2);
    idle(300, 2);
    // R1/R8: random traffic
    for (int i = 0; i < 40000; i++) begin
      int r = $urandom % 100;
      if (r < 2) begin
        int s = ($urandom % 4 == 0) ? ($urandom % 8) : ($urandom % 2);
        step(1'b1, 0, ($urandom & 16'hffe0) | (s << 2) | ($urandom % 4));
      end else if (r < 4) begin
        step(1'b1, 1, $urandom % (MAXV + 1));
      end else if (r < 6) begin
        step(1'b1, 3, $urandom % 2);
      end else begin
        int a = ($urandom % 4 == 0) ? ($urandom % 4) : 2;
        step(1'b0, a, 0);
      end
    end
    idle(4, 2);
    summary();
    $finish;
  end
endmodule